// File: doc/BRIEF.md
# Two-Stage Split-Carry Pipelined Adder

This block adds two unsigned operands through a two-register pipeline. It takes a fresh operand pair on every clock and returns one full-width sum on every clock. Each sum appears a fixed two clocks after its operands were sampled. The operand width is split into a lower part and an upper part. In the first stage both parts are added at the same time, and each part keeps its own carry. In the second stage the lower-part carry is folded into the upper-part sum through a single adder carry-in, and the result is joined with the registered lower bits.

A qualifier bit travels beside the data through both stages. Only this qualifier is cleared by the synchronous reset. The data registers have no reset, so synthesis may retime them. Downstream logic uses the sum only in cycles where the output qualifier is high.

The default build uses 30-bit operands split at bit 15 and produces a 31-bit sum.

Top module: `scs_adder`

## Requirements
- R1: When `out_vld` is high, `out_sum` equals the 31-bit unsigned sum `in_a + in_b` of the operand pair sampled exactly two rising clock edges earlier.
- R2: A new operand pair may be applied on every clock cycle. With back-to-back valid inputs, a correct result appears on every clock, in input order, with no gaps.
- R3: A carry out of the low half (bits 14..0) propagates into the high half (bits 29..15). For example, 0x00007FFF + 0x00000001 gives 0x00008000.
- R4: Bit 30 of `out_sum` is the overall carry-out. For example, 0x3FFFFFFF + 0x3FFFFFFF gives 0x7FFFFFFE, and 0x3FFFFFFF + 0x00000001 gives 0x40000000.
- R5: `out_vld` equals `in_vld` delayed by exactly two rising edges. An idle input cycle (`in_vld` low) produces an idle output cycle two clocks later, and the results on either side of it are unaffected.
- R6: While `rst` is high at a rising edge, both pipeline qualifiers are cleared, and operands presented with `in_vld` high during reset are discarded. After reset is released, `out_vld` stays low until valid data applied after reset reaches the output two clocks later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; clears the qualifiers only |
| in_a | input | 30 | First unsigned operand |
| in_b | input | 30 | Second unsigned operand |
| in_vld | input | 1 | Marks the operand pair as valid in this cycle |
| out_sum | output | 31 | Unsigned sum, with bit 30 as the carry-out |
| out_vld | output | 1 | Marks `out_sum` as valid |

## Verification
The hardest case to reach from the ports is a low-half carry meeting a high-half sum that is one short of overflowing. In that case the single carry-in must ripple through every upper bit into bit 30. Random operands almost never produce it. The stimulus therefore applies all-ones patterns in the low half, in the high half, and in both halves together. It places these patterns back to back with ordinary random pairs, so a carry that leaks into a neighbouring cycle would show up. A reset is also asserted in the middle of a stream, with valid operands still driven, to show that those operands never surface.

// File: rtl/scs_add_pkg.sv
package scs_add_pkg;

    // Default operand width and split point of the adder.
    localparam int unsigned OPW_DEF   = 30;
    localparam int unsigned SPLIT_DEF = 15;

    // Register stages between the operand inputs and the sum output.
    localparam int unsigned STAGES = 2;

endpackage

// File: rtl/scs_half_add.sv
// First-stage adder for one operand slice. The slice sum is registered
// together with its own carry-out. The data register has no reset.
module scs_half_add #(
    parameter int unsigned W = 15
) (
    input  logic         clk,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W:0]   s_q
);

    typedef struct packed {
        logic [W:0] sum;
    } half_st_t;

    half_st_t nx_d;
    half_st_t st_q;

    always_comb begin
        nx_d     = st_q;
        nx_d.sum = {1'b0, x} + {1'b0, y};
    end

    always_ff @(posedge clk) begin
        st_q <= nx_d;
    end

    assign s_q = st_q.sum;

endmodule

// File: rtl/scs_carry_merge.sv
// Second stage. The low-slice carry enters the high-slice sum through the
// carry-in of one adder: a constant 1 sits below the high sum, the carry
// sits below zero, and the least significant bit of the result is dropped.
module scs_carry_merge #(
    parameter int unsigned LO_W = 15,
    parameter int unsigned HI_W = 15
) (
    input  logic                 clk,
    input  logic [LO_W:0]        lo_q,
    input  logic [HI_W:0]        hi_q,
    output logic [LO_W+HI_W:0]   sum_q
);

    localparam int unsigned HI_P1 = HI_W + 1;
    localparam int unsigned SUM_W = LO_W + HI_W + 1;

    typedef struct packed {
        logic [SUM_W-1:0] sum;
    } merge_st_t;

    merge_st_t        nx_d;
    merge_st_t        st_q;
    logic [HI_W+1:0]  ext_d;
    logic [HI_W:0]    top_d;

    always_comb begin
        ext_d    = {hi_q, 1'b1} + {{HI_P1{1'b0}}, lo_q[LO_W]};
        top_d    = HI_P1'(ext_d >> 1);
        nx_d     = st_q;
        nx_d.sum = {top_d, lo_q[LO_W-1:0]};
    end

    always_ff @(posedge clk) begin
        st_q <= nx_d;
    end

    assign sum_q = st_q.sum;

endmodule

// File: rtl/scs_valid_pipe.sv
// Qualifier shift register. It is the only state that the synchronous
// reset clears.
module scs_valid_pipe #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic in_vld,
    output logic out_vld
);

    typedef struct packed {
        logic [DEPTH-1:0] sr;
    } vpipe_st_t;

    vpipe_st_t nx_d;
    vpipe_st_t st_q;

    always_comb begin
        nx_d    = st_q;
        nx_d.sr = (st_q.sr << 1) | {{(DEPTH-1){1'b0}}, in_vld};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= nx_d;
        end
    end

    assign out_vld = st_q.sr[DEPTH-1];

endmodule

// File: rtl/scs_adder.sv
// Top level: two-stage split-carry pipelined unsigned adder.
module scs_adder #(
    parameter int unsigned OP_W  = scs_add_pkg::OPW_DEF,
    parameter int unsigned SPLIT = scs_add_pkg::SPLIT_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] in_a,
    input  logic [OP_W-1:0] in_b,
    input  logic            in_vld,
    output logic [OP_W:0]   out_sum,
    output logic            out_vld
);

    localparam int unsigned LO_W  = SPLIT;
    localparam int unsigned HI_W  = OP_W - SPLIT;
    localparam int unsigned BUS_W = OP_W + 2;

    // Stage-1 results: the low slice in [LO_W:0], the high slice above it.
    logic [BUS_W-1:0] s1_bus;

    for (genvar g = 0; g < 2; g++) begin : g_slice
        localparam int unsigned SW   = (g == 0) ? LO_W : HI_W;
        localparam int unsigned BASE = (g == 0) ? 0 : LO_W;
        localparam int unsigned OFS  = (g == 0) ? 0 : LO_W + 1;

        scs_half_add #(
            .W (SW)
        ) i_half (
            .clk (clk),
            .x   (in_a[BASE +: SW]),
            .y   (in_b[BASE +: SW]),
            .s_q (s1_bus[OFS +: SW + 1])
        );
    end

    scs_carry_merge #(
        .LO_W (LO_W),
        .HI_W (HI_W)
    ) i_merge (
        .clk   (clk),
        .lo_q  (s1_bus[LO_W:0]),
        .hi_q  (s1_bus[BUS_W-1:LO_W+1]),
        .sum_q (out_sum)
    );

    scs_valid_pipe #(
        .DEPTH (scs_add_pkg::STAGES)
    ) i_vpipe (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_vld),
        .out_vld (out_vld)
    );

endmodule

// File: rtl/scs_adder_chk.sv
module scs_adder_chk #(
    parameter int unsigned OP_W  = 30,
    parameter int unsigned SPLIT = 15
) (
    input logic            clk,
    input logic            rst,
    input logic [OP_W-1:0] in_a,
    input logic [OP_W-1:0] in_b,
    input logic            in_vld,
    input logic [OP_W:0]   out_sum,
    input logic            out_vld
);

    logic [1:0]       seen_q;
    logic [OP_W:0]    full_ref;
    logic [SPLIT-1:0] lo_ref;

    assign full_ref = {1'b0, in_a} + {1'b0, in_b};
    assign lo_ref   = in_a[SPLIT-1:0] + in_b[SPLIT-1:0];

    // Counts the edges since reset, up to two, so that no property looks
    // back into the reset period.
    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 2'd0;
        end else if (seen_q != 2'd2) begin
            seen_q <= seen_q + 2'd1;
        end
    end

    a_r1_sum_matches: assert property (@(posedge clk) disable iff (rst)
        (seen_q == 2'd2 && out_vld) |-> out_sum == $past(full_ref, 2));

    a_r3_low_slice: assert property (@(posedge clk) disable iff (rst)
        (seen_q == 2'd2 && out_vld) |-> out_sum[SPLIT-1:0] == $past(lo_ref, 2));

    a_r4_carry_out: assert property (@(posedge clk) disable iff (rst)
        (seen_q == 2'd2 && out_vld) |-> out_sum[OP_W] == $past(full_ref[OP_W], 2));

    a_r5_valid_delay: assert property (@(posedge clk) disable iff (rst)
        (seen_q == 2'd2) |-> out_vld == $past(in_vld, 2));

    a_r6_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_vld);

endmodule

bind scs_adder scs_adder_chk #(
    .OP_W  (OP_W),
    .SPLIT (SPLIT)
) i_chk (
    .clk     (clk),
    .rst     (rst),
    .in_a    (in_a),
    .in_b    (in_b),
    .in_vld  (in_vld),
    .out_sum (out_sum),
    .out_vld (out_vld)
);

// File: tb/test_scs_adder.sv
`timescale 1ns/1ps
module test_scs_adder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [29:0] in_a = '0;
    logic [29:0] in_b = '0;
    logic        in_vld = 1'b0;
    logic [30:0] out_sum;
    logic        out_vld;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Expectations for the results due one (e1) and two (e2) negedges later.
    bit          e1_chk = 1'b0, e2_chk = 1'b0;
    bit          e1_v = 1'b0,   e2_v = 1'b0;
    logic [30:0] e1_s = '0,     e2_s = '0;
    string       e1_t = "",     e2_t = "";

    always #2 clk = ~clk;

    scs_adder i_scs_adder (
        .clk     (clk),
        .rst     (rst),
        .in_a    (in_a),
        .in_b    (in_b),
        .in_vld  (in_vld),
        .out_sum (out_sum),
        .out_vld (out_vld)
    );

    // One cycle: check the result that is due now, then drive the next inputs.
    task automatic step(input logic [29:0] a, input logic [29:0] b,
                        input bit v, input bit r, input string tag);
        @(negedge clk);
        if (e2_chk) begin
            n_run++;
            if (out_vld !== e2_v) begin
                n_fail++;
                $display("FAIL %s out_vld got %b exp %b", e2_t, out_vld, e2_v);
            end
            if (e2_v) begin
                n_run++;
                if (out_sum !== e2_s) begin
                    n_fail++;
                    $display("FAIL %s out_sum got %h exp %h", e2_t, out_sum, e2_s);
                end
            end
        end
        e2_chk = e1_chk; e2_v = e1_v; e2_s = e1_s; e2_t = e1_t;
        rst    = r;
        in_a   = a;
        in_b   = b;
        in_vld = v;
        e1_chk = 1'b1;
        e1_v   = v && !r;
        e1_s   = {1'b0, a} + {1'b0, b};
        e1_t   = tag;
        if (r) begin
            // R6: a reset at the next edge clears both qualifiers.
            e2_chk = 1'b1; e2_v = 1'b0; e2_t = tag;
        end
    endtask

    task automatic flush(input string tag);
        step('0, '0, 1'b0, 1'b0, tag);
        step('0, '0, 1'b0, 1'b0, tag);
    endtask

    task automatic t_reset();
        // R6: valid operands driven during reset are discarded.
        step(30'h1234, 30'h1, 1'b1, 1'b1, "R6");
        step(30'h5, 30'h6, 1'b1, 1'b1, "R6");
        step(30'h7, 30'h8, 1'b1, 1'b1, "R6");
        step('0, '0, 1'b0, 1'b0, "R6");
        flush("R6");
    endtask

    task automatic t_basic();
        step(30'd1234, 30'd5678, 1'b1, 1'b0, "R1");
        step(30'd0, 30'd0, 1'b1, 1'b0, "R1");
        step(30'h2AAA_AAAA, 30'h1555_5555, 1'b1, 1'b0, "R1");
        flush("R1");
    endtask

    task automatic t_ripple();
        step(30'h0000_7FFF, 30'h0000_0001, 1'b1, 1'b0, "R3");
        step(30'h0000_7FFF, 30'h0000_7FFF, 1'b1, 1'b0, "R3");
        step(30'h1FFF_FFFF, 30'h0000_0001, 1'b1, 1'b0, "R3");
        step(30'h0000_4000, 30'h0000_4000, 1'b1, 1'b0, "R3");
        flush("R3");
    endtask

    task automatic t_carry_out();
        step(30'h3FFF_FFFF, 30'h3FFF_FFFF, 1'b1, 1'b0, "R4");
        step(30'h3FFF_FFFF, 30'h0000_0001, 1'b1, 1'b0, "R4");
        step(30'h3FFF_8000, 30'h0000_8000, 1'b1, 1'b0, "R4");
        step(30'h3FFF_FFFF, 30'h0000_0000, 1'b1, 1'b0, "R4");
        flush("R4");
    endtask

    task automatic t_stream();
        for (int i = 0; i < 40; i++) begin
            logic [29:0] a, b;
            a = 30'($urandom);
            b = 30'($urandom);
            if (i % 5 == 0) a[14:0] = '1;
            if (i % 7 == 0) b[29:15] = '1;
            step(a, b, 1'b1, 1'b0, "R2");
        end
        flush("R2");
    endtask

    task automatic t_bubbles();
        for (int i = 0; i < 12; i++) begin
            step(30'($urandom), 30'($urandom), (i % 3) != 1, 1'b0, "R5");
        end
        flush("R5");
    endtask

    task automatic t_mid_reset();
        step(30'h0000_7FFF, 30'h1, 1'b1, 1'b0, "R6");
        step(30'h3FFF_FFFF, 30'h3FFF_FFFF, 1'b1, 1'b0, "R6");
        step(30'h1111, 30'h2222, 1'b1, 1'b1, "R6");
        step(30'h3333, 30'h4444, 1'b1, 1'b0, "R6");
        step(30'h0ABC_DEF0, 30'h0123_4567, 1'b1, 1'b0, "R6");
        flush("R6");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_ripple();
        t_carry_out();
        t_stream();
        t_bubbles();
        t_mid_reset();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL R2 watchdog got timeout exp completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule